// File: doc/BRIEF.md
# UART Interrupt Source and Mask Controller

This block gathers the four event classes of a serial port (receive, error, transmit and modem) into one level-sensitive interrupt request. Each event pulse latches a bit in a source register. A mask register decides which latched sources may reach the request line. The pending value is the source register with the masked bits removed, and the interrupt line is high while any pending bit is set. Software clears serviced events by writing ones either to the pending view or to the source view.

The block also raises the transmit event by itself when the FIFO is enabled and the transmit FIFO holds no more entries than a threshold. The threshold is a 3-bit code in the FIFO control word scaled by a factor that depends on the channel number, which is fixed when the block is built. The comparison is made every cycle, so the transmit source bit keeps reasserting for as long as the FIFO stays at or below the threshold.

Top module: `uart_irq_ctrl`

## Requirements
- R1: The source bits are receive in bit 0, error in bit 1, transmit in bit 2 and modem in bit 3. An event pulse sets its bit at the next rising clock edge, and the bit then holds.
- R2: The pending output equals source AND NOT mask in the same cycle. `irq` is high exactly when at least one pending bit is set.
- R3: A cycle with `wr_pend` high clears every source bit (and so every pending bit) whose `wr_data` bit is 1, at the next edge. Bits written with 0 are kept.
- R4: A cycle with `wr_src` high clears every source bit whose `wr_data` bit is 1, at the next edge.
- R5: A cycle with `wr_mask` high loads `wr_data` into the mask at the next edge. Pending and `irq` reflect the new mask in the cycle that follows, with no further event needed.
- R6: In `fifo_ctrl`, bit 0 enables FIFO mode and bits 10:8 hold the transmit trigger code. When bit 0 is 1 and `tx_count` is less than or equal to the trigger level, the transmit source bit is set at the next edge. This is evaluated every cycle. When bit 0 is 0 the threshold sets nothing. The receive trigger code in bits 6:4 has no effect.
- R7: The trigger level is the code times 32 for channel 0, times 8 for channels 1 and 4, and times 2 for channels 2 and 3. For any other channel number the level is 0.
- R8: A pulse on `ev_tx_done` (a completed transmit write) sets the transmit source bit.
- R9: When a bit is set and cleared in the same cycle, the set wins and the bit ends up 1.
- R10: During and right after reset the source and mask registers are 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_rx | input | 1 | Receive event pulse |
| ev_err | input | 1 | Error event pulse |
| ev_tx_done | input | 1 | Completed transmit write pulse |
| ev_modem | input | 1 | Modem event pulse |
| tx_count | input | CNT_W | Current transmit FIFO fill count |
| fifo_ctrl | input | CTRL_W | FIFO control word (enable bit 0, transmit code bits 10:8) |
| wr_pend | input | 1 | Write strobe, clear-by-one on the pending view |
| wr_src | input | 1 | Write strobe, clear-by-one on the source register |
| wr_mask | input | 1 | Write strobe, load of the mask register |
| wr_data | input | 4 | Write data shared by the three strobes |
| src_q | output | 4 | Source register value |
| pend_q | output | 4 | Pending value (source AND NOT mask) |
| mask_q | output | 4 | Mask register value |
| irq | output | 1 | Level interrupt request |

## Verification
A source bit that is set or cleared at the wrong time shows on `src_q` at the first edge after the stimulus, and on `pend_q` and `irq` in the same cycle unless the bit is masked. A wrong threshold factor or compare boundary only appears as a transmit bit that sets or fails to set exactly at counts equal to the level and one above it, so the bench probes those two counts and uses three channel settings. A stale mask shows as `irq` disagreeing with `src_q` and `mask_q` in the cycle after a mask write.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int SRC_N   = 4;
  localparam int B_RX    = 0;
  localparam int B_ERR   = 1;
  localparam int B_TX    = 2;
  localparam int B_MDM   = 3;

  localparam int FC_EN   = 0;
  localparam int FC_TXLO = 8;
  localparam int CODE_W  = 3;

  // scale applied to the 3-bit trigger code for a given channel
  function automatic int unsigned chan_factor(input int chan);
    case (chan)
      0:       return 32;
      1, 4:    return 8;
      2, 3:    return 2;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned tx_level(input int chan, input logic [CODE_W-1:0] code);
    return chan_factor(chan) * 32'(code);
  endfunction

endpackage

// File: rtl/uart_irq_txthr.sv
module uart_irq_txthr
  import uart_irq_pkg::*;
#(
  parameter int CHANNEL = 0,
  parameter int CNT_W   = 8,
  parameter int CTRL_W  = 16
) (
  input  logic [CNT_W-1:0]  tx_count,
  input  logic [CTRL_W-1:0] fifo_ctrl,
  output logic              thr_hit
);

  logic [CODE_W-1:0] code;
  int unsigned       level;

  assign code  = fifo_ctrl[FC_TXLO +: CODE_W];
  assign level = tx_level(CHANNEL, code);

  assign thr_hit = fifo_ctrl[FC_EN] && (32'(tx_count) <= level);

endmodule

// File: rtl/uart_irq_srcreg.sv
module uart_irq_srcreg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] src_q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        src_q[i] <= 1'b0;
      else if (set_vec[i])
        src_q[i] <= 1'b1;
      else if (clr_vec[i])
        src_q[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_irq_combine.sv
module uart_irq_combine #(
  parameter int N = 4
) (
  input  logic [N-1:0] src_q,
  input  logic [N-1:0] mask_q,
  output logic [N-1:0] pend,
  output logic         irq
);

  assign pend = src_q & ~mask_q;
  assign irq  = |pend;

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int CHANNEL = 0,
  parameter int CNT_W   = 8,
  parameter int CTRL_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_rx,
  input  logic              ev_err,
  input  logic              ev_tx_done,
  input  logic              ev_modem,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic [CTRL_W-1:0] fifo_ctrl,
  input  logic              wr_pend,
  input  logic              wr_src,
  input  logic              wr_mask,
  input  logic [3:0]        wr_data,
  output logic [3:0]        src_q,
  output logic [3:0]        pend_q,
  output logic [3:0]        mask_q,
  output logic              irq
);

  logic             thr_hit;
  logic [SRC_N-1:0] set_vec;
  logic [SRC_N-1:0] clr_vec;

  uart_irq_txthr #(
    .CHANNEL (CHANNEL),
    .CNT_W   (CNT_W),
    .CTRL_W  (CTRL_W)
  ) u_thr (
    .tx_count  (tx_count),
    .fifo_ctrl (fifo_ctrl),
    .thr_hit   (thr_hit)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[B_RX]   = ev_rx;
    set_vec[B_ERR]  = ev_err;
    set_vec[B_TX]   = ev_tx_done | thr_hit;
    set_vec[B_MDM]  = ev_modem;
  end

  assign clr_vec = (wr_pend | wr_src) ? wr_data : '0;

  uart_irq_srcreg #(.N(SRC_N)) u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .src_q   (src_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= '0;
    else if (wr_mask)
      mask_q <= wr_data;
  end

  uart_irq_combine #(.N(SRC_N)) u_comb (
    .src_q  (src_q),
    .mask_q (mask_q),
    .pend   (pend_q),
    .irq    (irq)
  );

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
  parameter int CHANNEL = 0,
  parameter int CNT_W   = 8,
  parameter int CTRL_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_rx,
  input logic              ev_err,
  input logic              ev_tx_done,
  input logic              ev_modem,
  input logic [CTRL_W-1:0] fifo_ctrl,
  input logic              wr_pend,
  input logic              wr_src,
  input logic              wr_mask,
  input logic [3:0]        wr_data,
  input logic [3:0]        src_q,
  input logic [3:0]        pend_q,
  input logic [3:0]        mask_q,
  input logic              irq,
  input logic              thr_hit
);

  // R1
  rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx |=> src_q[0]);

  // R8
  txdone_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_done |=> src_q[2]);

  // R6
  thr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_hit |=> src_q[2]);

  // R6
  thr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_ctrl[0] |-> !thr_hit);

  // R4
  src_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_src && wr_data[1] && !ev_err) |=> !src_q[1]);

  // R3
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && wr_data[3] && !ev_modem) |=> !src_q[3]);

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(wr_data)));

  // R2
  unmasked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_q & ~mask_q) != 4'b0) |-> irq);

  // R2
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & mask_q) == 4'b0));

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(
  .CHANNEL (CHANNEL),
  .CNT_W   (CNT_W),
  .CTRL_W  (CTRL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_rx      (ev_rx),
  .ev_err     (ev_err),
  .ev_tx_done (ev_tx_done),
  .ev_modem   (ev_modem),
  .fifo_ctrl  (fifo_ctrl),
  .wr_pend    (wr_pend),
  .wr_src     (wr_src),
  .wr_mask    (wr_mask),
  .wr_data    (wr_data),
  .src_q      (src_q),
  .pend_q     (pend_q),
  .mask_q     (mask_q),
  .irq        (irq),
  .thr_hit    (thr_hit)
);

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;

  typedef struct packed {
    logic [3:0]  ev;     // {modem, tx_done, err, rx}
    logic        ws;
    logic        wp;
    logic        wm;
    logic [3:0]  wd;
    logic [7:0]  cnt;
    logic [15:0] fc;
    logic [3:0]  es;
    logic [3:0]  ep;
    logic        ei;
  } row_t;

  localparam int NROW = 17;
  localparam row_t VECS [NROW] = '{
    '{4'b0001,1'b0,1'b0,1'b0,4'b0000,8'd0,  16'h0000,4'b0001,4'b0001,1'b1}, // R1 rx
    '{4'b0000,1'b0,1'b0,1'b1,4'b0001,8'd0,  16'h0000,4'b0001,4'b0000,1'b0}, // R5 mask rx
    '{4'b0010,1'b0,1'b0,1'b0,4'b0000,8'd0,  16'h0000,4'b0011,4'b0010,1'b1}, // R1 err
    '{4'b0000,1'b0,1'b1,1'b0,4'b0010,8'd0,  16'h0000,4'b0001,4'b0000,1'b0}, // R3 clear err
    '{4'b0000,1'b0,1'b0,1'b1,4'b0000,8'd0,  16'h0000,4'b0001,4'b0001,1'b1}, // R5 unmask
    '{4'b0000,1'b1,1'b0,1'b0,4'b0001,8'd0,  16'h0000,4'b0000,4'b0000,1'b0}, // R4 clear rx
    '{4'b1000,1'b0,1'b0,1'b0,4'b0000,8'd0,  16'h0000,4'b1000,4'b1000,1'b1}, // R1 modem
    '{4'b0100,1'b0,1'b0,1'b0,4'b0000,8'd0,  16'h0000,4'b1100,4'b1100,1'b1}, // R8 tx done
    '{4'b0000,1'b0,1'b1,1'b0,4'b1100,8'd0,  16'h0000,4'b0000,4'b0000,1'b0}, // R3 clear two
    '{4'b0000,1'b0,1'b0,1'b0,4'b0000,8'd32, 16'h0101,4'b0100,4'b0100,1'b1}, // R6 count==level
    '{4'b0000,1'b0,1'b1,1'b0,4'b0100,8'd33, 16'h0101,4'b0000,4'b0000,1'b0}, // R6 count>level
    '{4'b0000,1'b0,1'b0,1'b0,4'b0000,8'd0,  16'h0100,4'b0000,4'b0000,1'b0}, // R6 fifo off
    '{4'b0000,1'b0,1'b0,1'b0,4'b0000,8'd1,  16'h0071,4'b0000,4'b0000,1'b0}, // R6 rx code ignored
    '{4'b0000,1'b0,1'b0,1'b0,4'b0000,8'd0,  16'h0071,4'b0100,4'b0100,1'b1}, // R6 code 0 count 0
    '{4'b0000,1'b1,1'b0,1'b0,4'b0100,8'd224,16'h0701,4'b0100,4'b0100,1'b1}, // R9 thr beats clear
    '{4'b0000,1'b1,1'b0,1'b0,4'b0100,8'd225,16'h0701,4'b0000,4'b0000,1'b0}, // R6 above max level
    '{4'b0001,1'b1,1'b0,1'b0,4'b0001,8'd0,  16'h0000,4'b0001,4'b0001,1'b1}  // R9 event beats clear
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_rx = 0, ev_err = 0, ev_tx_done = 0, ev_modem = 0;
  logic [7:0]  tx_count = 0;
  logic [15:0] fifo_ctrl = 0;
  logic        wr_pend = 0, wr_src = 0, wr_mask = 0;
  logic [3:0]  wr_data = 0;
  logic [3:0]  src_q, pend_q, mask_q;
  logic        irq;
  logic [3:0]  src3, pend3, mask3, src6, pend6, mask6;
  logic        irq3, irq6;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_irq_ctrl #(.CHANNEL(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_rx(ev_rx), .ev_err(ev_err),
    .ev_tx_done(ev_tx_done), .ev_modem(ev_modem), .tx_count(tx_count),
    .fifo_ctrl(fifo_ctrl), .wr_pend(wr_pend), .wr_src(wr_src),
    .wr_mask(wr_mask), .wr_data(wr_data), .src_q(src_q), .pend_q(pend_q),
    .mask_q(mask_q), .irq(irq));

  uart_irq_ctrl #(.CHANNEL(3)) u_dut_ch3 (
    .clk(clk), .rst_n(rst_n), .ev_rx(ev_rx), .ev_err(ev_err),
    .ev_tx_done(ev_tx_done), .ev_modem(ev_modem), .tx_count(tx_count),
    .fifo_ctrl(fifo_ctrl), .wr_pend(wr_pend), .wr_src(wr_src),
    .wr_mask(wr_mask), .wr_data(wr_data), .src_q(src3), .pend_q(pend3),
    .mask_q(mask3), .irq(irq3));

  uart_irq_ctrl #(.CHANNEL(6)) u_dut_ch6 (
    .clk(clk), .rst_n(rst_n), .ev_rx(ev_rx), .ev_err(ev_err),
    .ev_tx_done(ev_tx_done), .ev_modem(ev_modem), .tx_count(tx_count),
    .fifo_ctrl(fifo_ctrl), .wr_pend(wr_pend), .wr_src(wr_src),
    .wr_mask(wr_mask), .wr_data(wr_data), .src_q(src6), .pend_q(pend6),
    .mask_q(mask6), .irq(irq6));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // apply one cycle of inputs at a falling edge, sample at the next falling edge
  task automatic step(input logic [3:0] ev, input logic ws, input logic wp,
                      input logic wm, input logic [3:0] wd,
                      input logic [7:0] cnt, input logic [15:0] fc);
    {ev_modem, ev_tx_done, ev_err, ev_rx} = ev;
    wr_src = ws; wr_pend = wp; wr_mask = wm; wr_data = wd;
    tx_count = cnt; fifo_ctrl = fc;
    @(posedge clk);
    @(negedge clk);
    {ev_modem, ev_tx_done, ev_err, ev_rx} = 4'b0;
    wr_src = 0; wr_pend = 0; wr_mask = 0; wr_data = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not complete");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 state while in reset
    check(src_q == 4'b0 && mask_q == 4'b0, "R10 in reset", {src_q, mask_q}, 0);
    check(irq == 1'b0, "R10 irq in reset", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(src_q == 4'b0 && pend_q == 4'b0 && !irq, "R10 after reset", {src_q, pend_q}, 0);

    for (int i = 0; i < NROW; i++) begin
      row_t r = VECS[i];
      step(r.ev, r.ws, r.wp, r.wm, r.wd, r.cnt, r.fc);
      check(src_q == r.es, $sformatf("R1 src row %0d", i), src_q, r.es);
      check(pend_q == r.ep && irq == r.ei, $sformatf("R2 pend/irq row %0d", i),
            {pend_q, 3'b0, irq}, {r.ep, 3'b0, r.ei});
    end

    // R5 mask readback and immediate effect on irq
    step(4'b0000, 0, 0, 1, 4'b1011, 8'd0, 16'h0000);
    check(mask_q == 4'b1011, "R5 mask readback", mask_q, 4'b1011);
    check(pend_q == 4'b0000 && !irq, "R5 masked rx quiet", {pend_q, irq}, 0);
    step(4'b0000, 0, 0, 1, 4'b0000, 8'd0, 16'h0000);
    check(irq == 1'b1 && pend_q == 4'b0001, "R5 unmask raises irq", {pend_q, irq}, 5'b00011);

    // R3 pending write leaves untouched bits
    step(4'b1010, 0, 0, 0, 4'b0000, 8'd0, 16'h0000);
    step(4'b0000, 0, 1, 0, 4'b0010, 8'd0, 16'h0000);
    check(src_q == 4'b1001, "R3 partial clear", src_q, 4'b1001);

    // R7 channel scaling: code 3 gives 96 / 6 / 0
    step(4'b0000, 0, 1, 0, 4'b1111, 8'd0, 16'h0000);
    step(4'b0000, 0, 0, 0, 4'b0000, 8'd7, 16'h0301);
    check(src_q[2] == 1'b1, "R7 ch0 count 7 level 96", src_q[2], 1);
    check(src3[2] == 1'b0, "R7 ch3 count 7 level 6", src3[2], 0);
    check(src6[2] == 1'b0, "R7 ch6 count 7 level 0", src6[2], 0);
    step(4'b0000, 0, 1, 0, 4'b0100, 8'd0, 16'h0000);
    step(4'b0000, 0, 0, 0, 4'b0000, 8'd6, 16'h0301);
    check(src3[2] == 1'b1, "R7 ch3 count 6 level 6", src3[2], 1);
    check(src6[2] == 1'b0, "R7 ch6 count 6 level 0", src6[2], 0);
    step(4'b0000, 0, 1, 0, 4'b0100, 8'd0, 16'h0000);
    step(4'b0000, 0, 0, 0, 4'b0000, 8'd0, 16'h0301);
    check(src6[2] == 1'b1, "R7 ch6 count 0 level 0", src6[2], 1);

    summary();
  end

endmodule